// File: doc/BRIEF.md
# HDLC receive deframer

This block recovers frames from a bit-synchronous serial line. A bit is taken from the line whenever the selected bit enable is high. The enable comes from one of two sources: an internal bit-rate strobe or a strobe derived from an external receive clock. Both strobes arrive already aligned to the system clock. The block looks for the flag byte, deletes the zeros that the transmitter inserted after runs of five ones, packs the surviving bits into bytes and runs a 16-bit CRC over every bit between the flags.

Payload bytes leave on a byte stream with a valid strobe. The last two bytes before the closing flag are the frame check sequence. The block keeps bytes back internally so that these two bytes never reach the output. A frame-end strobe is raised on the last payload byte and carries one status bit: good, CRC error or non-octet. An aborted frame produces a frame-end strobe with the abort status and no byte. Frames too short to carry any payload vanish without a trace.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: After reset, and until the first frame ends, byte_valid_o and frame_end_o are low.
- R2: The bit sequence 0,1,1,1,1,1,1,0 (a six-ones run enclosed by zeros) is a flag that opens and closes frames. Consecutive flags, and flags that share their boundary zero, produce no output.
- R3: Inside a frame, a 0 that follows five consecutive 1s is deleted. This applies even when the run spans a byte boundary.
- R4: Bytes are assembled with the first received data bit as bit 0. Payload bytes come out in line order, each as a one-cycle byte_valid_o pulse.
- R5: The two bytes before the closing flag (the check sequence) are never output. frame_end_o on a completed frame coincides with byte_valid_o on the last payload byte.
- R6: The CRC register is preset to 0xFFFF at frame start and shifted LSB-first with polynomial x^16+x^12+x^5+1 (reflected constant 0x8408) over all bits between the flags. A frame whose register ends at 0xF0B8 and whose length is a multiple of 8 reports frame_good_o.
- R7: An octet-aligned frame whose final CRC register differs from 0xF0B8 delivers its payload and reports frame_crc_err_o.
- R8: A seventh consecutive 1 inside a frame aborts it. If any data bit was committed, the block raises frame_end_o with frame_abort_o and no byte. The block then ignores the line until the next flag.
- R9: A frame holding fewer than three whole bytes after destuffing produces no byte and no frame-end strobe.
- R10: A frame whose destuffed length is not a multiple of 8 reports frame_nonoct_o. Its trailing partial byte is dropped, and whole bytes other than the last two are delivered.
- R11: With src_ext_i high only ext_bit_en_i clocks bits in, and int_bit_en_i has no effect. With src_ext_i low the reverse holds.
- R12: The status outputs are high only together with frame_end_o, and exactly one of them is high at each frame end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_ext_i | input | 1 | 1 selects the external bit enable, 0 the internal one |
| int_bit_en_i | input | 1 | Bit strobe from the internal rate generator |
| ext_bit_en_i | input | 1 | Bit strobe derived from the external receive clock |
| rx_bit_i | input | 1 | Serial line data |
| byte_valid_o | output | 1 | A payload byte is on byte_data_o |
| byte_data_o | output | 8 | Payload byte |
| frame_end_o | output | 1 | Frame finished (with the last byte, or alone on abort) |
| frame_good_o | output | 1 | Status: CRC residue correct |
| frame_crc_err_o | output | 1 | Status: CRC residue wrong |
| frame_abort_o | output | 1 | Status: frame aborted |
| frame_nonoct_o | output | 1 | Status: length not a multiple of 8 bits |

## Verification
The timing checks assume that each bit strobe is a single-cycle pulse, already synchronous to clk. They also assume that src_ext_i changes only while the line is idle between frames, so that any output can be traced back to a selected strobe one or two cycles earlier. The stimulus drives every bit as a one-cycle strobe followed by a quiet cycle and holds rx_bit_i steady around the strobe. It switches the clock source only after the closing and idle flags have been sent. During the external-source frame it holds the internal strobe permanently high, so that any leak from the unselected source corrupts the frame.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned RUN_W  = 3;
  localparam int unsigned PIPE_D = 7;
  localparam int unsigned PCNT_W = 3;

  localparam logic [RUN_W-1:0]  STUFF_RUN = 3'd5;
  localparam logic [RUN_W-1:0]  FLAG_RUN  = 3'd6;
  localparam logic [RUN_W-1:0]  RUN_SAT   = 3'd7;
  localparam logic [PCNT_W-1:0] PIPE_FULL = 3'd7;

  typedef enum logic [2:0] {
    EV_NONE,
    EV_DATA,
    EV_STUFF,
    EV_FLAG,
    EV_ABORT
  } line_ev_e;
endpackage

// File: rtl/hdlc_rx_srcsel.sv
module hdlc_rx_srcsel (
  input  logic src_ext_i,
  input  logic int_en_i,
  input  logic ext_en_i,
  output logic bit_en_o
);
  always_comb begin
    bit_en_o = src_ext_i ? ext_en_i : int_en_i;
  end
endmodule

// File: rtl/hdlc_rx_linedet.sv
module hdlc_rx_linedet
  import hdlc_rx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en_i,
  input  logic bit_i,
  output logic commit_en_o,
  output logic commit_bit_o,
  output logic open_o,
  output logic close_o,
  output logic abort_o
);
  logic [RUN_W-1:0]  ones_q, ones_n;
  logic              frame_q, frame_n;
  logic [PIPE_D-1:0] pipe_q, pipe_n;
  logic [PCNT_W-1:0] pcnt_q, pcnt_n;
  logic              last0_q, last0_n;
  logic              push;
  line_ev_e          ev;

  // classify the incoming bit
  always_comb begin
    ev = EV_NONE;
    if (bit_en_i) begin
      if (bit_i)                  ev = (ones_q >= FLAG_RUN) ? EV_ABORT : EV_DATA;
      else if (ones_q == FLAG_RUN)  ev = EV_FLAG;
      else if (ones_q == STUFF_RUN) ev = EV_STUFF;
      else                          ev = EV_DATA;
    end
  end

  // next state: seven-bit holding pipe so flag bits never reach the byte path
  always_comb begin
    ones_n       = ones_q;
    frame_n      = frame_q;
    pipe_n       = pipe_q;
    pcnt_n       = pcnt_q;
    last0_n      = last0_q;
    push         = 1'b0;
    commit_en_o  = 1'b0;
    commit_bit_o = pipe_q[0];
    open_o       = 1'b0;
    close_o      = 1'b0;
    abort_o      = 1'b0;
    case (ev)
      EV_DATA: begin
        ones_n = bit_i ? ones_q + 1'b1 : '0;
        push   = frame_q;
      end
      EV_STUFF: begin
        ones_n  = '0;
        last0_n = 1'b0;
      end
      EV_FLAG: begin
        ones_n = '0;
        if (frame_q) begin
          close_o     = 1'b1;
          commit_en_o = (pcnt_q == PIPE_FULL) && !last0_q;
        end else begin
          open_o = 1'b1;
        end
        frame_n = 1'b1;
        pcnt_n  = '0;
        last0_n = 1'b0;
      end
      EV_ABORT: begin
        ones_n  = RUN_SAT;
        abort_o = frame_q;
        frame_n = 1'b0;
        pcnt_n  = '0;
      end
      default: ;
    endcase
    if (push) begin
      commit_en_o = (pcnt_q == PIPE_FULL);
      pipe_n      = {bit_i, pipe_q[PIPE_D-1:1]};
      if (pcnt_q != PIPE_FULL) pcnt_n = pcnt_q + 1'b1;
      if (!bit_i) last0_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ones_q  <= '0;
      frame_q <= 1'b0;
      pipe_q  <= '0;
      pcnt_q  <= '0;
      last0_q <= 1'b0;
    end else begin
      ones_q  <= ones_n;
      frame_q <= frame_n;
      pipe_q  <= pipe_n;
      pcnt_q  <= pcnt_n;
      last0_q <= last0_n;
    end
  end
endmodule

// File: rtl/hdlc_rx_crc.sv
module hdlc_rx_crc #(
  parameter int unsigned      W    = 16,
  parameter logic [W-1:0]     INIT = '1,
  parameter logic [W-1:0]     POLY = 16'h8408
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         init_i,
  input  logic         en_i,
  input  logic         bit_i,
  output logic [W-1:0] crc_o
);
  logic [W-1:0] crc_q, crc_n;

  always_comb begin
    crc_n = crc_q;
    if (init_i)
      crc_n = INIT;
    else if (en_i)
      crc_n = (crc_q[0] ^ bit_i) ? ((crc_q >> 1) ^ POLY) : (crc_q >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= INIT;
    else        crc_q <= crc_n;
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
  import hdlc_rx_pkg::*;
#(
  parameter int unsigned          CRC_W    = 16,
  parameter logic [CRC_W-1:0]     CRC_INIT = '1,
  parameter logic [CRC_W-1:0]     CRC_POLY = 16'h8408,
  parameter logic [CRC_W-1:0]     CRC_GOOD = 16'hF0B8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_ext_i,
  input  logic              int_bit_en_i,
  input  logic              ext_bit_en_i,
  input  logic              rx_bit_i,
  output logic              byte_valid_o,
  output logic [BYTE_W-1:0] byte_data_o,
  output logic              frame_end_o,
  output logic              frame_good_o,
  output logic              frame_crc_err_o,
  output logic              frame_abort_o,
  output logic              frame_nonoct_o
);
  localparam int unsigned HOLD_N = CRC_W / BYTE_W + 1;
  localparam int unsigned CNT_W  = $clog2(HOLD_N + 1);
  localparam int unsigned BIT_W  = $clog2(BYTE_W);

  logic             bit_en;
  logic             c_en, c_bit, ev_open, ev_close, ev_abort;
  logic             clear;
  logic [CRC_W-1:0] crc;

  logic [BIT_W-1:0]  bitcnt_q, bitcnt_n;
  logic [BYTE_W-1:0] sr_q, sr_n, new_byte;
  logic [BYTE_W-1:0] hold_q [HOLD_N];
  logic [BYTE_W-1:0] hold_n [HOLD_N];
  logic [CNT_W-1:0]  hcnt_q, hcnt_n;
  logic              any_q, any_n;
  logic              close_q;

  logic              valid_n, end_n, good_n, cerr_n, abrt_n, nono_n;
  logic [BYTE_W-1:0] data_n;
  logic              aligned, res_ok;

  hdlc_rx_srcsel u_src (
    .src_ext_i (src_ext_i),
    .int_en_i  (int_bit_en_i),
    .ext_en_i  (ext_bit_en_i),
    .bit_en_o  (bit_en)
  );

  hdlc_rx_linedet u_line (
    .clk          (clk),
    .rst_n        (rst_n),
    .bit_en_i     (bit_en),
    .bit_i        (rx_bit_i),
    .commit_en_o  (c_en),
    .commit_bit_o (c_bit),
    .open_o       (ev_open),
    .close_o      (ev_close),
    .abort_o      (ev_abort)
  );

  assign clear = ev_open | ev_abort | close_q;

  hdlc_rx_crc #(.W(CRC_W), .INIT(CRC_INIT), .POLY(CRC_POLY)) u_crc (
    .clk    (clk),
    .rst_n  (rst_n),
    .init_i (clear),
    .en_i   (c_en),
    .bit_i  (c_bit),
    .crc_o  (crc)
  );

  assign new_byte = {c_bit, sr_q[BYTE_W-1:1]};
  assign aligned  = (bitcnt_q == '0);
  assign res_ok   = (crc == CRC_GOOD);

  always_comb begin
    bitcnt_n = bitcnt_q;
    sr_n     = sr_q;
    hcnt_n   = hcnt_q;
    any_n    = any_q;
    for (int i = 0; i < HOLD_N; i++) hold_n[i] = hold_q[i];
    valid_n = 1'b0;
    end_n   = 1'b0;
    good_n  = 1'b0;
    cerr_n  = 1'b0;
    abrt_n  = 1'b0;
    nono_n  = 1'b0;
    data_n  = '0;

    // byte assembly, LSB first; bytes wait in the hold line until the CRC is known
    if (c_en) begin
      sr_n     = new_byte;
      bitcnt_n = bitcnt_q + 1'b1;
      any_n    = 1'b1;
      if (bitcnt_q == BIT_W'(BYTE_W - 1)) begin
        if (hcnt_q == CNT_W'(HOLD_N)) begin
          valid_n = 1'b1;
          data_n  = hold_q[0];
          for (int i = 0; i < HOLD_N - 1; i++) hold_n[i] = hold_q[i+1];
          hold_n[HOLD_N-1] = new_byte;
        end else begin
          for (int i = 0; i < HOLD_N; i++)
            if (CNT_W'(i) == hcnt_q) hold_n[i] = new_byte;
          hcnt_n = hcnt_q + 1'b1;
        end
      end
    end

    // frame close: last payload byte is the oldest held byte
    if (close_q && hcnt_q == CNT_W'(HOLD_N)) begin
      valid_n = 1'b1;
      data_n  = hold_q[0];
      end_n   = 1'b1;
      good_n  = aligned && res_ok;
      cerr_n  = aligned && !res_ok;
      nono_n  = !aligned;
    end

    if (ev_abort && any_q) begin
      end_n  = 1'b1;
      abrt_n = 1'b1;
    end

    if (clear) begin
      bitcnt_n = '0;
      hcnt_n   = '0;
      any_n    = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitcnt_q        <= '0;
      sr_q            <= '0;
      hcnt_q          <= '0;
      any_q           <= 1'b0;
      close_q         <= 1'b0;
      for (int i = 0; i < HOLD_N; i++) hold_q[i] <= '0;
      byte_valid_o    <= 1'b0;
      byte_data_o     <= '0;
      frame_end_o     <= 1'b0;
      frame_good_o    <= 1'b0;
      frame_crc_err_o <= 1'b0;
      frame_abort_o   <= 1'b0;
      frame_nonoct_o  <= 1'b0;
    end else begin
      bitcnt_q        <= bitcnt_n;
      sr_q            <= sr_n;
      hcnt_q          <= hcnt_n;
      any_q           <= any_n;
      close_q         <= ev_close;
      for (int i = 0; i < HOLD_N; i++) hold_q[i] <= hold_n[i];
      byte_valid_o    <= valid_n;
      byte_data_o     <= data_n;
      frame_end_o     <= end_n;
      frame_good_o    <= good_n;
      frame_crc_err_o <= cerr_n;
      frame_abort_o   <= abrt_n;
      frame_nonoct_o  <= nono_n;
    end
  end
endmodule

// File: rtl/hdlc_rx_deframer_chk.sv
module hdlc_rx_deframer_chk (
  input logic clk,
  input logic rst_n,
  input logic src_ext_i,
  input logic int_bit_en_i,
  input logic ext_bit_en_i,
  input logic byte_valid_o,
  input logic frame_end_o,
  input logic frame_good_o,
  input logic frame_crc_err_o,
  input logic frame_abort_o,
  input logic frame_nonoct_o
);
  logic sel_en;
  assign sel_en = src_ext_i ? ext_bit_en_i : int_bit_en_i;

  // R1
  quiet_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!byte_valid_o && !frame_end_o));

  // R12
  status_with_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_good_o || frame_crc_err_o || frame_abort_o || frame_nonoct_o) |-> frame_end_o);

  // R12
  single_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end_o |-> ($countones({frame_good_o, frame_crc_err_o, frame_abort_o, frame_nonoct_o}) == 1));

  // R8
  abort_no_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_abort_o |-> !byte_valid_o);

  // R5
  end_on_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end_o && !frame_abort_o) |-> byte_valid_o);

  // R11
  byte_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid_o |-> ($past(sel_en) || $past(sel_en, 2)));
endmodule

bind hdlc_rx_deframer hdlc_rx_deframer_chk chk_i (
  .clk             (clk),
  .rst_n           (rst_n),
  .src_ext_i       (src_ext_i),
  .int_bit_en_i    (int_bit_en_i),
  .ext_bit_en_i    (ext_bit_en_i),
  .byte_valid_o    (byte_valid_o),
  .frame_end_o     (frame_end_o),
  .frame_good_o    (frame_good_o),
  .frame_crc_err_o (frame_crc_err_o),
  .frame_abort_o   (frame_abort_o),
  .frame_nonoct_o  (frame_nonoct_o)
);

// File: tb/hdlc_rx_deframer_tb_top.sv
`timescale 1ns/1ps
module hdlc_rx_deframer_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, src_ext, int_en, ext_en, rx_bit;
  logic       b_valid, f_end, f_good, f_cerr, f_abort, f_nono;
  logic [7:0] b_data;

  hdlc_rx_deframer dut_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .src_ext_i       (src_ext),
    .int_bit_en_i    (int_en),
    .ext_bit_en_i    (ext_en),
    .rx_bit_i        (rx_bit),
    .byte_valid_o    (b_valid),
    .byte_data_o     (b_data),
    .frame_end_o     (f_end),
    .frame_good_o    (f_good),
    .frame_crc_err_o (f_cerr),
    .frame_abort_o   (f_abort),
    .frame_nonoct_o  (f_nono)
  );

  localparam logic [3:0] ST_GOOD = 4'b1000;
  localparam logic [3:0] ST_CERR = 4'b0100;
  localparam logic [3:0] ST_ABRT = 4'b0010;
  localparam logic [3:0] ST_NONO = 4'b0001;

  int         nchk = 0, nfail = 0;
  int         gn = 0, ends = 0, so = 0;
  logic [7:0] got [64];
  logic [7:0] pl  [32];
  logic [3:0] st = '0;
  logic       end_v = 1'b0;
  logic       int_hi = 1'b0;
  logic       done = 1'b0;

  // output monitor, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (b_valid) begin
        if (gn < 64) got[gn] = b_data;
        gn++;
      end
      if (f_end) begin
        ends++;
        st    = {f_good, f_cerr, f_abort, f_nono};
        end_v = b_valid;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tx_bit(input logic b);
    @(negedge clk);
    rx_bit = b;
    if (src_ext) ext_en = 1'b1; else int_en = 1'b1;
    @(negedge clk);
    ext_en = 1'b0;
    if (!int_hi) int_en = 1'b0;
  endtask

  task automatic tx_flag();
    tx_bit(1'b0);
    for (int i = 0; i < 6; i++) tx_bit(1'b1);
    tx_bit(1'b0);
    so = 0;
  endtask

  task automatic tx_dbit(input logic b);
    tx_bit(b);
    if (b) begin
      so++;
      if (so == 5) begin
        tx_bit(1'b0);
        so = 0;
      end
    end else so = 0;
  endtask

  task automatic tx_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) tx_dbit(v[i]);
  endtask

  function automatic logic [15:0] fcs_upd(input logic [15:0] c, input logic [7:0] v);
    logic [15:0] r = c;
    for (int i = 0; i < 8; i++)
      r = (r[0] ^ v[i]) ? ((r >> 1) ^ 16'h8408) : (r >> 1);
    return r;
  endfunction

  task automatic start_obs();
    repeat (2) @(negedge clk);
    gn = 0; ends = 0; st = '0; end_v = 1'b0;
  endtask

  task automatic tail_idle();
    tx_flag();
    repeat (6) @(negedge clk);
  endtask

  task automatic send_frame(input int n, input bit bad);
    logic [15:0] c = 16'hFFFF;
    logic [15:0] f;
    start_obs();
    tx_flag();
    for (int i = 0; i < n; i++) begin
      tx_byte(pl[i]);
      c = fcs_upd(c, pl[i]);
    end
    f = ~c;
    if (bad) f = f ^ 16'h0100;
    tx_byte(f[7:0]);
    tx_byte(f[15:8]);
    tx_flag();
    tail_idle();
  endtask

  task automatic expect_frame(input string req, input int n, input logic [3:0] est);
    chk(gn == n, {req, " byte count"}, gn, n);
    for (int i = 0; i < n && i < 64; i++)
      chk(got[i] == pl[i], {req, " byte value"}, got[i], pl[i]);
    chk(ends == 1, {req, " one frame end"}, ends, 1);
    chk(end_v == 1'b1, {req, " end on last byte"}, end_v, 1);
    chk(st == est, {req, " status"}, st, est);
  endtask

  task automatic expect_none(input string req);
    chk(gn == 0, {req, " no byte"}, gn, 0);
    chk(ends == 0, {req, " no frame end"}, ends, 0);
  endtask

  // R1
  task automatic t_reset();
    rst_n = 1'b0; src_ext = 1'b0; int_en = 1'b0; ext_en = 1'b0; rx_bit = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(b_valid == 1'b0, "R1 valid low", b_valid, 0);
    chk(f_end == 1'b0, "R1 end low", f_end, 0);
  endtask

  // R4 R5 R6: good frame with stuffing inside payload
  task automatic t_good();
    pl[0] = 8'h12; pl[1] = 8'h7E; pl[2] = 8'hFF;
    send_frame(3, 1'b0);
    expect_frame("R6 R4 good", 3, ST_GOOD);
  endtask

  // R3: ones run straddling a byte boundary
  task automatic t_boundary();
    pl[0] = 8'hF8; pl[1] = 8'h0F; pl[2] = 8'h7E; pl[3] = 8'hBE;
    send_frame(4, 1'b0);
    expect_frame("R3 boundary", 4, ST_GOOD);
  endtask

  // R7
  task automatic t_crc_err();
    pl[0] = 8'hA5; pl[1] = 8'h5A; pl[2] = 8'h00; pl[3] = 8'h81;
    send_frame(4, 1'b1);
    expect_frame("R7 crc error", 4, ST_CERR);
  endtask

  // R5 long frame
  task automatic t_long();
    for (int i = 0; i < 20; i++) pl[i] = 8'(i * 37 + 5);
    send_frame(20, 1'b0);
    expect_frame("R5 long", 20, ST_GOOD);
  endtask

  // R8 abort, then recovery on next flag
  task automatic t_abort();
    start_obs();
    tx_flag();
    tx_byte(8'h33);
    tx_byte(8'h44);
    for (int i = 0; i < 8; i++) tx_bit(1'b1);
    repeat (6) @(negedge clk);
    chk(gn == 0, "R8 abort no byte", gn, 0);
    chk(ends == 1, "R8 abort end", ends, 1);
    chk(st == ST_ABRT, "R8 abort status", st, ST_ABRT);
    chk(end_v == 1'b0, "R8 abort end alone", end_v, 0);
    pl[0] = 8'h01; pl[1] = 8'h02; pl[2] = 8'h03;
    send_frame(3, 1'b0);
    expect_frame("R8 recovery", 3, ST_GOOD);
  endtask

  // R2
  task automatic t_flags();
    start_obs();
    tx_flag(); tx_flag(); tx_flag();
    tx_bit(1'b0);
    for (int k = 0; k < 3; k++) begin
      for (int i = 0; i < 6; i++) tx_bit(1'b1);
      tx_bit(1'b0);
    end
    repeat (6) @(negedge clk);
    expect_none("R2 flags only");
  endtask

  // R9
  task automatic t_short();
    start_obs();
    tx_flag();
    tx_byte(8'hA5);
    tail_idle();
    expect_none("R9 one byte");
    send_frame(0, 1'b0);
    expect_none("R9 check only");
  endtask

  // R10
  task automatic t_nonoct();
    pl[0] = 8'h11; pl[1] = 8'h22; pl[2] = 8'h44; pl[3] = 8'h88;
    start_obs();
    tx_flag();
    for (int i = 0; i < 4; i++) tx_byte(pl[i]);
    tx_dbit(1'b1); tx_dbit(1'b0); tx_dbit(1'b1);
    tx_flag();
    tail_idle();
    expect_frame("R10 nonoct", 2, ST_NONO);
  endtask

  // R11: external source while internal strobe held high
  task automatic t_ext();
    src_ext = 1'b1;
    int_hi  = 1'b1;
    int_en  = 1'b1;
    pl[0] = 8'h3C; pl[1] = 8'hC3; pl[2] = 8'h55;
    send_frame(3, 1'b0);
    expect_frame("R11 external", 3, ST_GOOD);
    int_hi  = 1'b0;
    int_en  = 1'b0;
    repeat (2) @(negedge clk);
    src_ext = 1'b0;
  endtask

  initial begin
    t_reset();
    tx_flag();
    t_good();
    t_boundary();
    t_crc_err();
    t_long();
    t_abort();
    t_flags();
    t_short();
    t_nonoct();
    t_ext();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end
endmodule